// File: doc/BRIEF.md
# Two-Wire Memory Page-Write Controller

This block sits behind the byte-level front end of a two-wire serial memory. The front end recovers START and STOP events and whole received bytes. This block decides which of those bytes to acknowledge and carries out write transactions into an internal byte array. A transaction opens with a device-select byte. Two word-address bytes follow, high byte first, and then one or more data bytes. The data bytes go into a page buffer that has one valid flag per byte. The buffer is not written to the array until the transaction closes.

A STOP that follows at least one data byte starts a timed programming cycle. While it runs, the `busy` output is high and every bus request is refused. On the last cycle of the programming time, every buffered byte that was actually received is committed to the array in a single step. Within a page, the address advances only in its low bits, so a long burst wraps around and overwrites its own earlier bytes. A registered lookup port exposes the array contents.

Top module: `page_write_ctrl`

## Requirements
- R1: A byte received as the first byte after START is acknowledged only if it equals {4'b1010, 1'b0, dev_sel[1:0], 1'b0}, where bit 0 = 0 means write. Any other value, including a read request (bit 0 = 1), is not acknowledged. No byte after it is acknowledged or stored until the next START.
- R2: After an acknowledged select, the next two bytes are acknowledged and form the word address, high byte first. Bits 7:6 of the high byte are ignored. Only word-address bits MEM_AW-1:0 select an array location.
- R3: Each data byte is acknowledged and buffered at page slot addr[5:0]. Then only addr[5:0] increments, wrapping from 63 to 0, and the upper address bits stay fixed.
- R4: When more than 64 data bytes arrive before STOP, the slot index wraps. A later byte in a slot replaces the earlier one, and only the last value is committed.
- R5: A STOP after at least one data byte raises `busy` at the next clock edge for exactly PROG_CYCLES cycles. The array reads its old contents while `busy` is high and holds the new bytes from the cycle after `busy` falls.
- R6: Only page slots that received a byte in the transaction are written. Every other array location keeps its contents.
- R7: While `busy` is high, no byte is acknowledged, and START, STOP and received bytes have no effect on the array or on the state after the cycle.
- R8: A STOP that arrives before any data byte ends the transaction without raising `busy` and without changing the array.
- R9: During and after reset, `bus_ack` and `busy` are low, the buffer is empty, and every array byte reads 0.
- R10: `mem_rdata` presents the array byte at `mem_raddr` one clock after the address is applied.
- R11: A repeated START before STOP discards all bytes buffered so far, so a following STOP with no new data programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 2 | Strapped device-select value compared with select-byte bits 2:1 |
| bus_start | input | 1 | One-cycle pulse: START detected |
| bus_stop | input | 1 | One-cycle pulse: STOP detected |
| rx_valid | input | 1 | One-cycle pulse: a whole byte has been received |
| rx_byte | input | 8 | The received byte, valid with rx_valid |
| bus_ack | output | 1 | High one cycle after a received byte that is to be acknowledged |
| busy | output | 1 | Programming cycle in progress |
| mem_raddr | input | MEM_AW | Array lookup address |
| mem_rdata | output | 8 | Array byte at mem_raddr, one cycle later |

## Verification
The write path is tried with a single byte, a short run in the middle of a page, and a 66-byte burst that starts two slots below the page end. These show apart a plain store, a store limited to the received slots, and wrap-around with overwrite. Refusal is tried with a foreign device code, a read request, a select sent while programming, and a STOP or repeated START before any data. Each of these must leave both the acknowledge line and the array untouched. Reads at aliased addresses and at neighbours of written slots confirm that the page base is fixed and that bytes land only where expected.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   typedef enum logic [2:0] {
      PW_IDLE,
      PW_SELECT,
      PW_ADDR_HI,
      PW_ADDR_LO,
      PW_DATA,
      PW_IGNORE,
      PW_PROGRAM
   } pw_state_e;

   localparam logic [3:0] PW_DEV_CODE = 4'b1010;
   localparam int         PW_BYTE_W   = 8;

endpackage

// File: rtl/pwc_seq.sv
module pwc_seq
   import pwc_pkg::*;
#(
   parameter int MEM_AW      = 11,
   parameter int PAGE_AW     = 6,
   parameter int PROG_CYCLES = 200
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         dev_sel,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic               rx_valid,
   input  logic [7:0]         rx_byte,
   input  logic               buf_any,
   output logic               bus_ack,
   output logic               busy,
   output logic               slot_wr,
   output logic [PAGE_AW-1:0] slot_idx,
   output logic               buf_clr,
   output logic               commit,
   output logic [MEM_AW-1:0]  word_addr
);

   localparam int CNT_W = $clog2(PROG_CYCLES);
   localparam int HI_W  = MEM_AW - 8;

   pw_state_e          st_q, st_d;
   logic [MEM_AW-1:0]  addr_q, addr_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic               ack_d;
   logic               sel_hit;

   assign sel_hit = (rx_byte[7:4] == PW_DEV_CODE) && !rx_byte[3]
                    && (rx_byte[2:1] == dev_sel) && !rx_byte[0];

   always_comb begin
      st_d    = st_q;
      addr_d  = addr_q;
      cnt_d   = cnt_q;
      ack_d   = 1'b0;
      slot_wr = 1'b0;
      buf_clr = 1'b0;
      commit  = 1'b0;
      if (st_q == PW_PROGRAM) begin
         if (cnt_q == '0) begin
            commit  = 1'b1;
            buf_clr = 1'b1;
            st_d    = PW_IDLE;
         end else begin
            cnt_d = cnt_q - 1'b1;
         end
      end else if (bus_start) begin
         st_d    = PW_SELECT;
         buf_clr = 1'b1;
      end else if (bus_stop) begin
         if (st_q == PW_DATA && buf_any) begin
            st_d  = PW_PROGRAM;
            cnt_d = CNT_W'(PROG_CYCLES - 1);
         end else begin
            st_d    = PW_IDLE;
            buf_clr = 1'b1;
         end
      end else if (rx_valid) begin
         case (st_q)
            PW_SELECT: begin
               if (sel_hit) begin
                  ack_d = 1'b1;
                  st_d  = PW_ADDR_HI;
               end else begin
                  st_d = PW_IGNORE;
               end
            end
            PW_ADDR_HI: begin
               addr_d[MEM_AW-1:8] = rx_byte[HI_W-1:0];
               ack_d = 1'b1;
               st_d  = PW_ADDR_LO;
            end
            PW_ADDR_LO: begin
               addr_d[7:0] = rx_byte;
               ack_d = 1'b1;
               st_d  = PW_DATA;
            end
            PW_DATA: begin
               ack_d   = 1'b1;
               slot_wr = 1'b1;
               addr_d[PAGE_AW-1:0] = addr_q[PAGE_AW-1:0] + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PW_IDLE;
         addr_q  <= '0;
         cnt_q   <= '0;
         bus_ack <= 1'b0;
      end else begin
         st_q    <= st_d;
         addr_q  <= addr_d;
         cnt_q   <= cnt_d;
         bus_ack <= ack_d;
      end
   end

   assign busy      = (st_q == PW_PROGRAM);
   assign slot_idx  = addr_q[PAGE_AW-1:0];
   assign word_addr = addr_q;

endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int PAGE_AW = 6,
   parameter int DATA_W  = 8
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 slot_wr,
   input  logic [PAGE_AW-1:0]                   slot_idx,
   input  logic [DATA_W-1:0]                    slot_data,
   input  logic                                 buf_clr,
   output logic [(1<<PAGE_AW)-1:0][DATA_W-1:0]  page_data,
   output logic [(1<<PAGE_AW)-1:0]              page_mask,
   output logic                                 buf_any
);

   localparam int SLOTS = 1 << PAGE_AW;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic hit;
      assign hit = slot_wr && (slot_idx == PAGE_AW'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            page_data[g] <= '0;
            page_mask[g] <= 1'b0;
         end else if (buf_clr) begin
            page_mask[g] <= 1'b0;
         end else if (hit) begin
            page_data[g] <= slot_data;
            page_mask[g] <= 1'b1;
         end
      end
   end

   assign buf_any = |page_mask;

endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
   parameter int MEM_AW   = 11,
   parameter int PAGE_AW  = 6,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 commit,
   input  logic [MEM_AW-1:PAGE_AW]              page_row,
   input  logic [(1<<PAGE_AW)-1:0][DATA_W-1:0]  page_data,
   input  logic [(1<<PAGE_AW)-1:0]              page_mask,
   input  logic [MEM_AW-1:0]                    rd_addr,
   output logic [DATA_W-1:0]                    rd_data
);

   localparam int DEPTH = 1 << MEM_AW;
   localparam int SLOTS = 1 << PAGE_AW;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) store[a] <= '0;
      end else if (commit) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (page_mask[s]) store[{page_row, PAGE_AW'(s)}] <= page_data[s];
         end
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= store[rd_addr];
      end
   end else begin : g_rd_comb
      assign rd_data = store[rd_addr];
   end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
   import pwc_pkg::*;
#(
   parameter int MEM_AW      = 11,
   parameter int PAGE_AW     = 6,
   parameter int PROG_CYCLES = 200,
   parameter bit READ_REG    = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        dev_sel,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              bus_ack,
   output logic              busy,
   input  logic [MEM_AW-1:0] mem_raddr,
   output logic [7:0]        mem_rdata
);

   localparam int SLOTS = 1 << PAGE_AW;

   if (MEM_AW < 9 || MEM_AW > 14) begin : g_bad_aw
      $error("page_write_ctrl: MEM_AW must lie in 9..14");
   end
   if (PAGE_AW < 1 || PAGE_AW >= MEM_AW || PAGE_AW > 8) begin : g_bad_page
      $error("page_write_ctrl: PAGE_AW must be below MEM_AW and at most 8");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("page_write_ctrl: PROG_CYCLES must be at least 2");
   end

   logic                                slot_wr, buf_clr, commit, buf_any;
   logic [PAGE_AW-1:0]                  slot_idx;
   logic [MEM_AW-1:0]                   word_addr;
   logic [SLOTS-1:0][PW_BYTE_W-1:0]     page_data;
   logic [SLOTS-1:0]                    page_mask;

   pwc_seq #(
      .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .buf_any(buf_any),
      .bus_ack(bus_ack), .busy(busy), .slot_wr(slot_wr),
      .slot_idx(slot_idx), .buf_clr(buf_clr), .commit(commit),
      .word_addr(word_addr)
   );

   pwc_page_buf #(
      .PAGE_AW(PAGE_AW), .DATA_W(PW_BYTE_W)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .slot_idx(slot_idx),
      .slot_data(rx_byte), .buf_clr(buf_clr), .page_data(page_data),
      .page_mask(page_mask), .buf_any(buf_any)
   );

   pwc_array #(
      .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .DATA_W(PW_BYTE_W), .READ_REG(READ_REG)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .page_row(word_addr[MEM_AW-1:PAGE_AW]), .page_data(page_data),
      .page_mask(page_mask), .rd_addr(mem_raddr), .rd_data(mem_rdata)
   );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
   parameter int PROG_CYCLES = 200
)(
   input logic clk,
   input logic rst_n,
   input logic bus_stop,
   input logic rx_valid,
   input logic bus_ack,
   input logic busy,
   input logic buf_any
);

   int busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_stop));

   assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == PROG_CYCLES));

   assert_no_prog_without_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(buf_any));

   assert_no_ack_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_valid) |=> !bus_ack);

   assert_ack_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> $past(rx_valid));

   assert_buffer_empty_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> !buf_any);

endmodule

bind page_write_ctrl pwc_checker #(.PROG_CYCLES(PROG_CYCLES)) u_pwc_checker (
   .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .rx_valid(rx_valid),
   .bus_ack(bus_ack), .busy(busy), .buf_any(buf_any)
);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;

   localparam int MEM_AW = 11;
   localparam int MEMSZ  = 1 << MEM_AW;
   localparam int PROG   = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        dev_sel = 2'b10;
   logic              bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
   logic [7:0]        rx_byte = 8'h00;
   logic              bus_ack, busy;
   logic [MEM_AW-1:0] mem_raddr = '0;
   logic [7:0]        mem_rdata;

   int tests = 0, fails = 0, cycles = 0;
   string cur_req = "R9";

   always #2 clk = ~clk;

   page_write_ctrl #(.MEM_AW(MEM_AW), .PAGE_AW(6), .PROG_CYCLES(PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .bus_start(bus_start),
      .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .bus_ack(bus_ack), .busy(busy), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
   );

   // behavioural reference: 0 idle,1 select,2 addr hi,3 addr lo,4 data,5 ignore
   int mmem [MEMSZ];
   int pbuf [64];
   bit pval [64];
   int mst = 0, maddr = 0, left = 0;
   bit m_busy = 0, m_ack = 0;
   int m_rdata = 0;

   function automatic bit any_val();
      for (int i = 0; i < 64; i++) if (pval[i]) return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEMSZ; i++) mmem[i] = 0;
         for (int i = 0; i < 64; i++) pval[i] = 0;
         mst = 0; maddr = 0; left = 0; m_busy = 0; m_ack = 0; m_rdata = 0;
      end else begin
         m_rdata = mmem[int'(mem_raddr)];
         m_ack = 0;
         if (m_busy) begin
            left--;
            if (left == 0) begin
               for (int i = 0; i < 64; i++)
                  if (pval[i]) mmem[((maddr / 64) * 64 + i) % MEMSZ] = pbuf[i];
               for (int i = 0; i < 64; i++) pval[i] = 0;
               m_busy = 0; mst = 0;
            end
         end else if (bus_start) begin
            mst = 1;
            for (int i = 0; i < 64; i++) pval[i] = 0;
         end else if (bus_stop) begin
            if (mst == 4 && any_val()) begin m_busy = 1; left = PROG; end
            else begin
               mst = 0;
               for (int i = 0; i < 64; i++) pval[i] = 0;
            end
         end else if (rx_valid) begin
            case (mst)
               1: if (rx_byte == {4'b1010, 1'b0, dev_sel, 1'b0}) begin m_ack = 1; mst = 2; end
                  else mst = 5;
               2: begin maddr = (maddr % 256) + 256 * (int'(rx_byte) % 64); m_ack = 1; mst = 3; end
               3: begin maddr = (maddr / 256) * 256 + int'(rx_byte); m_ack = 1; mst = 4; end
               4: begin
                  pbuf[maddr % 64] = int'(rx_byte);
                  pval[maddr % 64] = 1;
                  maddr = (maddr / 64) * 64 + ((maddr + 1) % 64);
                  m_ack = 1;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare against the reference on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         chk(bus_ack == m_ack, cur_req, int'(bus_ack), int'(m_ack));
         chk(busy == m_busy, "R5", int'(busy), int'(m_busy));
         chk(int'(mem_rdata) == m_rdata, "R10", int'(mem_rdata), m_rdata);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL R5 watchdog: actual=%0d expected<100000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   task automatic pulse_start();
      @(negedge clk) bus_start = 1'b1;
      @(negedge clk) bus_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) bus_stop = 1'b1;
      @(negedge clk) bus_stop = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
      @(negedge clk) rx_valid = 1'b0;
      chk(bus_ack == exp_ack, req, int'(bus_ack), int'(exp_ack));
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic rd(input int a, input int exp, input string req);
      @(negedge clk) mem_raddr = MEM_AW'(a);
      @(negedge clk);
      chk(int'(mem_rdata) == exp, req, int'(mem_rdata), exp);
   endtask

   initial begin
      int busy_len;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && bus_ack == 1'b0, "R9", int'({busy, bus_ack}), 0);
      rst_n = 1'b1;
      rd(12'h123, 0, "R9");

      // single byte write; top bits of high address byte ignored
      cur_req = "R2";
      pulse_start();
      send(8'hA4, 1, "R1");
      send(8'hC1, 1, "R2");
      send(8'h23, 1, "R2");
      send(8'h5A, 1, "R3");
      pulse_stop();
      chk(busy == 1'b1, "R5", int'(busy), 1);
      rd(12'h123, 0, "R5");
      busy_len = 2;
      while (busy) begin @(negedge clk); busy_len++; end
      chk(busy_len == PROG, "R5", busy_len, PROG);
      rd(12'h123, 8'h5A, "R5");

      // short page run mid-page; neighbours untouched
      cur_req = "R3";
      pulse_start();
      send(8'hA4, 1, "R1");
      send(8'h02, 1, "R2");
      send(8'h45, 1, "R2");
      send(8'h10, 1, "R3");
      send(8'h11, 1, "R3");
      send(8'h12, 1, "R3");
      pulse_stop();
      wait_idle();
      rd(12'h245, 8'h10, "R3");
      rd(12'h247, 8'h12, "R3");
      rd(12'h248, 0, "R6");
      rd(12'h244, 0, "R6");

      // 66-byte burst from slot 62: wraps within page 0x0A80
      cur_req = "R4";
      pulse_start();
      send(8'hA4, 1, "R1");
      send(8'h0A, 1, "R2");
      send(8'hBE, 1, "R2");
      for (int k = 0; k < 66; k++) send(8'(8'h20 + k), 1, "R4");
      pulse_stop();
      wait_idle();
      rd(12'hA80 + 62, 8'h60, "R4");
      rd(12'hA80 + 63, 8'h61, "R4");
      rd(12'hA80 + 0,  8'h22, "R4");
      rd(12'hA80 + 61, 8'h5F, "R4");
      rd(12'h280, 8'h22, "R2");
      rd(12'hAC0, 0, "R3");

      // foreign device code and read request
      cur_req = "R1";
      pulse_start();
      send(8'hA2, 0, "R1");
      send(8'h00, 0, "R1");
      send(8'h10, 0, "R1");
      send(8'h77, 0, "R1");
      pulse_stop();
      chk(busy == 1'b0, "R1", int'(busy), 0);
      rd(12'h010, 0, "R1");
      pulse_start();
      send(8'hA5, 0, "R1");
      send(8'h01, 0, "R1");
      pulse_stop();

      // stop before data
      cur_req = "R8";
      pulse_start();
      send(8'hA4, 1, "R8");
      send(8'h01, 1, "R8");
      send(8'h00, 1, "R8");
      pulse_stop();
      chk(busy == 1'b0, "R8", int'(busy), 0);
      rd(12'h100, 0, "R8");

      // requests while programming
      cur_req = "R7";
      pulse_start();
      send(8'hA4, 1, "R7");
      send(8'h00, 1, "R7");
      send(8'h05, 1, "R7");
      send(8'h33, 1, "R7");
      pulse_stop();
      pulse_start();
      send(8'hA4, 0, "R7");
      send(8'h44, 0, "R7");
      pulse_stop();
      chk(busy == 1'b1, "R7", int'(busy), 1);
      wait_idle();
      send(8'hA4, 0, "R7");
      rd(12'h005, 8'h33, "R7");
      rd(12'h006, 0, "R7");

      // repeated start discards buffered data
      cur_req = "R11";
      pulse_start();
      send(8'hA4, 1, "R11");
      send(8'h00, 1, "R11");
      send(8'h09, 1, "R11");
      send(8'h99, 1, "R11");
      pulse_start();
      send(8'hA4, 1, "R11");
      send(8'h00, 1, "R11");
      send(8'h0A, 1, "R11");
      pulse_stop();
      chk(busy == 1'b0, "R11", int'(busy), 0);
      rd(12'h009, 0, "R11");

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule